// File: doc/BRIEF.md
# Three-Bank Rotating Frame Buffer Controller

This block runs three equal memory banks as a pipeline with three stations: one bank takes incoming samples, one is held by a capture consumer, and one is held by a processing consumer. A sample stream is written in address order into the bank that currently has the acquisition role. When that bank holds a complete frame, all three roles move one step together. The bank that was just filled goes to capture. The bank that capture held goes to processing. The bank that processing held becomes the next acquisition bank.

A move is allowed only when every consumer holding a bank has reported that it is finished with it. If a frame fills before that, the controller raises an overflow flag and drops incoming samples until the move can take place. Each consumer gets its bank index, a valid flag and a one-cycle start pulse when a bank is handed to it. It reads its bank through its own address port. Read data appears one clock later. A count of completed rotations is output so that the rotation order can be followed from outside.

Top module: `tri_bank_rotator`

## Requirements
- R1: After reset the acquisition bank is 0, the write address is 0, overflow is low, both consumer valid flags and start pulses are low, and the rotation count is 0.
- R2: A sample offered with `in_valid` while overflow is low is accepted (`wr_accept` high). It is stored in the acquisition bank at the current write address, and the write address then advances by one.
- R3: If the sample at address BANK_DEPTH-1 is accepted while a valid consumer has not yet signalled done, no rotation takes place. Overflow goes high and the write address returns to 0. While overflow is high, samples are refused, and both the write address and the memory contents stay unchanged.
- R4: On a rotation, the acquisition bank moves from b to (b+1) mod 3. Capture takes the old acquisition bank, and processing takes the old capture bank.
- R5: Capture becomes valid after the first rotation and processing becomes valid after the second. Both stay valid from then on.
- R6: In the first cycle in which a consumer shows a newly assigned bank index, its start output is high for exactly that one cycle. Processing gets no start pulse while capture has never been valid.
- R7: The rotation count rises by exactly one on each rotation and stays constant otherwise.
- R8: A done that arrives in the same cycle as the frame-completing write counts toward that rotation. The rotation happens at once, without overflow.
- R9: While overflow is high, the rotation happens in the cycle in which the last missing done arrives, or in the next cycle if the dones are already registered. Overflow then falls. A sample offered in that cycle is dropped, and the write address stays 0.
- R10: Whenever both consumers are valid, the acquisition, capture and processing bank indices are pairwise different.
- R11: Each consumer's read data, one cycle after it presents a read address, equals the word stored at that address of the bank it held at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming sample present |
| in_data | input | DATA_W | Incoming sample value |
| wr_accept | output | 1 | Sample is accepted this cycle |
| wr_bank | output | 2 | Bank holding the acquisition role |
| wr_addr | output | AW | Address for the next accepted sample |
| overflow | output | 1 | Frame full and waiting on a consumer; samples dropped |
| cap_valid | output | 1 | Capture consumer holds a bank |
| cap_bank | output | 2 | Bank held by capture |
| cap_start | output | 1 | One-cycle pulse when a new capture bank is assigned |
| cap_done | input | 1 | Capture is finished with its bank |
| cap_raddr | input | AW | Capture read address |
| cap_rdata | output | DATA_W | Capture read data |
| proc_valid | output | 1 | Processing consumer holds a bank |
| proc_bank | output | 2 | Bank held by processing |
| proc_start | output | 1 | One-cycle pulse when a new processing bank is assigned |
| proc_done | input | 1 | Processing is finished with its bank |
| proc_raddr | input | AW | Processing read address |
| proc_rdata | output | DATA_W | Processing read data |
| frame_count | output | CNT_W | Number of rotations since reset |

## Verification
The delicate coincidence is a consumer's done arriving in the same clock as the write that completes a frame. The same collision appears in a second form: the last missing done arriving while overflow is already high, in the same cycle as a new sample. A directed step drives the final write together with both dones and expects an immediate rotation with no overflow. Another step releases the capture consumer while a sample is offered during overflow, and expects that rotation to happen with the sample discarded. A seeded random phase then mixes writes, dones and read addresses. Every cycle it compares all outputs against a bench model of the rotation rules.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   localparam int NUM_BANKS = 3;

   typedef logic [1:0] bank_idx_t;

   // successor in the fixed rotation 0 -> 1 -> 2 -> 0
   function automatic bank_idx_t bank_after(input bank_idx_t b);
      return (b == 2'd2) ? 2'd0 : b + 2'd1;
   endfunction
endpackage

// File: rtl/rpc_bank_ram.sv
module rpc_bank_ram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/rpc_acq_writer.sv
module rpc_acq_writer #(
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          hold,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          frame_full
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   logic [AW-1:0] addr_q;

   assign wr_en      = in_valid & ~hold;
   assign frame_full = wr_en & (addr_q == LAST_ADDR);
   assign wr_addr    = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_en) begin
         addr_q <= frame_full ? '0 : addr_q + 1'b1;
      end
   end
endmodule

// File: rtl/rpc_role_seq.sv
module rpc_role_seq
   import rpc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_full,
   input  logic             cap_done,
   input  logic             proc_done,
   output bank_idx_t        acq_bank,
   output bank_idx_t        cap_bank,
   output bank_idx_t        proc_bank,
   output logic             cap_valid,
   output logic             proc_valid,
   output logic             cap_start,
   output logic             proc_start,
   output logic             pending,
   output logic [CNT_W-1:0] frame_count
);
   bank_idx_t        acq_q, cap_q, proc_q;
   logic             cap_v_q, proc_v_q;
   logic             cap_rel_q, proc_rel_q;
   logic             cap_st_q, proc_st_q;
   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;

   logic cap_free, proc_free, want_rot, rotate;

   // a consumer with no bank, or one that has finished, does not block
   assign cap_free  = ~cap_v_q  | cap_rel_q  | cap_done;
   assign proc_free = ~proc_v_q | proc_rel_q | proc_done;
   assign want_rot  = frame_full | pend_q;
   assign rotate    = want_rot & cap_free & proc_free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acq_q      <= 2'd0;
         cap_q      <= 2'd0;
         proc_q     <= 2'd0;
         cap_v_q    <= 1'b0;
         proc_v_q   <= 1'b0;
         cap_rel_q  <= 1'b0;
         proc_rel_q <= 1'b0;
         cap_st_q   <= 1'b0;
         proc_st_q  <= 1'b0;
         pend_q     <= 1'b0;
         cnt_q      <= '0;
      end else if (rotate) begin
         acq_q      <= bank_after(acq_q);
         cap_q      <= acq_q;
         proc_q     <= cap_q;
         cap_v_q    <= 1'b1;
         proc_v_q   <= cap_v_q;
         cap_rel_q  <= 1'b0;
         proc_rel_q <= 1'b0;
         cap_st_q   <= 1'b1;
         proc_st_q  <= cap_v_q;
         pend_q     <= 1'b0;
         cnt_q      <= cnt_q + 1'b1;
      end else begin
         cap_rel_q  <= cap_rel_q  | (cap_done  & cap_v_q);
         proc_rel_q <= proc_rel_q | (proc_done & proc_v_q);
         cap_st_q   <= 1'b0;
         proc_st_q  <= 1'b0;
         pend_q     <= want_rot;
      end
   end

   assign acq_bank    = acq_q;
   assign cap_bank    = cap_q;
   assign proc_bank   = proc_q;
   assign cap_valid   = cap_v_q;
   assign proc_valid  = proc_v_q;
   assign cap_start   = cap_st_q;
   assign proc_start  = proc_st_q;
   assign pending     = pend_q;
   assign frame_count = cnt_q;
endmodule

// File: rtl/tri_bank_rotator.sv
module tri_bank_rotator
   import rpc_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int BANK_DEPTH = 16,
   parameter int CNT_W      = 16,
   parameter bit READ_REG   = 1'b1,
   localparam int AW        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              wr_accept,
   output logic [1:0]        wr_bank,
   output logic [AW-1:0]     wr_addr,
   output logic              overflow,
   output logic              cap_valid,
   output logic [1:0]        cap_bank,
   output logic              cap_start,
   input  logic              cap_done,
   input  logic [AW-1:0]     cap_raddr,
   output logic [DATA_W-1:0] cap_rdata,
   output logic              proc_valid,
   output logic [1:0]        proc_bank,
   output logic              proc_start,
   input  logic              proc_done,
   input  logic [AW-1:0]     proc_raddr,
   output logic [DATA_W-1:0] proc_rdata,
   output logic [CNT_W-1:0]  frame_count
);
   if (BANK_DEPTH < 2) begin : g_bad_depth
      $error("tri_bank_rotator: BANK_DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tri_bank_rotator: DATA_W must be positive");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tri_bank_rotator: CNT_W must be at least 2");
   end

   logic      frame_full, hold;
   bank_idx_t acq_b, cap_b, proc_b;

   rpc_acq_writer #(.DEPTH(BANK_DEPTH)) u_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .hold       (hold),
      .wr_en      (wr_accept),
      .wr_addr    (wr_addr),
      .frame_full (frame_full)
   );

   rpc_role_seq #(.CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_full  (frame_full),
      .cap_done    (cap_done),
      .proc_done   (proc_done),
      .acq_bank    (acq_b),
      .cap_bank    (cap_b),
      .proc_bank   (proc_b),
      .cap_valid   (cap_valid),
      .proc_valid  (proc_valid),
      .cap_start   (cap_start),
      .proc_start  (proc_start),
      .pending     (hold),
      .frame_count (frame_count)
   );

   assign overflow  = hold;
   assign wr_bank   = acq_b;
   assign cap_bank  = cap_b;
   assign proc_bank = proc_b;

   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [AW-1:0] rd_addr;
      logic          wr_here;

      // a bank is read by whichever consumer currently holds it
      assign rd_addr = (cap_b == bank_idx_t'(b)) ? cap_raddr : proc_raddr;
      assign wr_here = wr_accept & (acq_b == bank_idx_t'(b));

      rpc_bank_ram #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_ram (
         .clk   (clk),
         .we    (wr_here),
         .waddr (wr_addr),
         .wdata (in_data),
         .raddr (rd_addr),
         .rdata (bank_rd[b])
      );
   end

   logic [DATA_W-1:0] cap_sel, proc_sel;

   always_comb begin
      cap_sel = bank_rd[0];
      case (cap_b)
         2'd1:    cap_sel = bank_rd[1];
         2'd2:    cap_sel = bank_rd[2];
         default: cap_sel = bank_rd[0];
      endcase
   end

   always_comb begin
      proc_sel = bank_rd[0];
      case (proc_b)
         2'd1:    proc_sel = bank_rd[1];
         2'd2:    proc_sel = bank_rd[2];
         default: proc_sel = bank_rd[0];
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] cap_q, proc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_q  <= '0;
            proc_q <= '0;
         end else begin
            cap_q  <= cap_sel;
            proc_q <= proc_sel;
         end
      end
      assign cap_rdata  = cap_q;
      assign proc_rdata = proc_q;
   end else begin : g_rd_comb
      assign cap_rdata  = cap_sel;
      assign proc_rdata = proc_sel;
   end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
   import rpc_pkg::*;
#(
   parameter int AW    = 4,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_accept,
   input logic [1:0]       wr_bank,
   input logic [AW-1:0]    wr_addr,
   input logic             overflow,
   input logic             cap_valid,
   input logic [1:0]       cap_bank,
   input logic             cap_start,
   input logic             proc_valid,
   input logic [1:0]       proc_bank,
   input logic             proc_start,
   input logic [CNT_W-1:0] frame_count
);
   assert_no_overflow_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !wr_accept);

   assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && $past(overflow)) |-> $stable(wr_addr));

   assert_cap_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start |-> (cap_bank == $past(wr_bank) && wr_bank == bank_after($past(wr_bank))));

   assert_proc_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      proc_start |-> (proc_valid && proc_bank == $past(cap_bank)));

   assert_proc_after_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      proc_valid |-> cap_valid);

   assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start |=> !cap_start);

   assert_proc_start_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      proc_start |-> cap_start);

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start |-> frame_count == $past(frame_count) + CNT_W'(1));

   assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_start |-> $stable(frame_count));

   assert_overflow_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overflow) |-> (cap_start && wr_addr == '0));

   assert_distinct_banks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      proc_valid |-> (wr_bank != cap_bank && wr_bank != proc_bank && cap_bank != proc_bank));
endmodule

bind tri_bank_rotator rpc_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_accept   (wr_accept),
   .wr_bank     (wr_bank),
   .wr_addr     (wr_addr),
   .overflow    (overflow),
   .cap_valid   (cap_valid),
   .cap_bank    (cap_bank),
   .cap_start   (cap_start),
   .proc_valid  (proc_valid),
   .proc_bank   (proc_bank),
   .proc_start  (proc_start),
   .frame_count (frame_count)
);

// File: tb/tri_bank_rotator_bench.sv
module tri_bank_rotator_bench;
   localparam int DW    = 16;
   localparam int DEPTH = 8;
   localparam int CW    = 16;
   localparam int AW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          wr_accept;
   logic [1:0]    wr_bank;
   logic [AW-1:0] wr_addr;
   logic          overflow;
   logic          cap_valid, cap_start, proc_valid, proc_start;
   logic [1:0]    cap_bank, proc_bank;
   logic          cap_done = 1'b0, proc_done = 1'b0;
   logic [AW-1:0] cap_raddr = '0, proc_raddr = '0;
   logic [DW-1:0] cap_rdata, proc_rdata;
   logic [CW-1:0] frame_count;

   tri_bank_rotator #(.DATA_W(DW), .BANK_DEPTH(DEPTH), .CNT_W(CW), .READ_REG(1'b1)) u_tri_bank_rotator (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .wr_accept(wr_accept), .wr_bank(wr_bank), .wr_addr(wr_addr), .overflow(overflow),
      .cap_valid(cap_valid), .cap_bank(cap_bank), .cap_start(cap_start), .cap_done(cap_done),
      .cap_raddr(cap_raddr), .cap_rdata(cap_rdata),
      .proc_valid(proc_valid), .proc_bank(proc_bank), .proc_start(proc_start), .proc_done(proc_done),
      .proc_raddr(proc_raddr), .proc_rdata(proc_rdata), .frame_count(frame_count)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model of the rotation rules
   int          m_acq, m_cb, m_pb, m_wa, m_fc;
   bit          m_cv, m_pv, m_pend, m_crel, m_prel, m_cs, m_ps;
   logic [DW-1:0] mem [3][DEPTH];

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int next_bank(input int b);
      return (b + 1) % 3;
   endfunction

   task automatic step(input bit iv, input logic [DW-1:0] id, input bit cd, input bit pd,
                       input logic [AW-1:0] cra, input logic [AW-1:0] pra);
      bit accept, full, cfree, pfree, rot, crd_ok, prd_ok;
      logic [DW-1:0] e_crd, e_prd;
      in_valid = iv; in_data = id; cap_done = cd; proc_done = pd;
      cap_raddr = cra; proc_raddr = pra;
      accept = iv && !m_pend;
      full   = accept && (m_wa == DEPTH - 1);
      cfree  = !m_cv || m_crel || cd;
      pfree  = !m_pv || m_prel || pd;
      rot    = (full || m_pend) && cfree && pfree;
      crd_ok = m_cv; prd_ok = m_pv;
      e_crd  = mem[m_cb][cra];
      e_prd  = mem[m_pb][pra];
      if (accept) mem[m_acq][m_wa] = id;
      if (accept) m_wa = full ? 0 : m_wa + 1;
      if (rot) begin
         m_pb = m_cb; m_pv = m_cv; m_ps = m_cv;
         m_cb = m_acq; m_cv = 1'b1; m_cs = 1'b1;
         m_acq = next_bank(m_acq);
         m_crel = 1'b0; m_prel = 1'b0; m_pend = 1'b0;
         m_fc++;
      end else begin
         m_crel = m_crel || (cd && m_cv);
         m_prel = m_prel || (pd && m_pv);
         m_pend = full || m_pend;
         m_cs = 1'b0; m_ps = 1'b0;
      end
      @(posedge clk);
      #1;
      chk("R4 wr_bank", wr_bank, m_acq);
      chk("R2 wr_addr", wr_addr, m_wa);
      chk("R3 overflow", overflow, m_pend);
      chk("R5 cap_valid", cap_valid, m_cv);
      chk("R5 proc_valid", proc_valid, m_pv);
      if (m_cv) chk("R4 cap_bank", cap_bank, m_cb);
      if (m_pv) chk("R4 proc_bank", proc_bank, m_pb);
      chk("R6 cap_start", cap_start, m_cs);
      chk("R6 proc_start", proc_start, m_ps);
      chk("R7 frame_count", frame_count, m_fc);
      if (crd_ok) chk("R11 cap_rdata", cap_rdata, e_crd);
      if (prd_ok) chk("R11 proc_rdata", proc_rdata, e_prd);
      if (cap_valid && proc_valid)
         chk("R10 distinct", (wr_bank != cap_bank && wr_bank != proc_bank && cap_bank != proc_bank), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      m_acq = 0; m_cb = 0; m_pb = 0; m_wa = 0; m_fc = 0;
      m_cv = 0; m_pv = 0; m_pend = 0; m_crel = 0; m_prel = 0; m_cs = 0; m_ps = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 wr_bank", wr_bank, 0);
      chk("R1 wr_addr", wr_addr, 0);
      chk("R1 overflow", overflow, 0);
      chk("R1 valids", {cap_valid, proc_valid}, 0);
      chk("R1 starts", {cap_start, proc_start}, 0);
      chk("R1 frame_count", frame_count, 0);
      rst_n = 1'b1;

      // first frame: no consumers yet, rotation is free
      for (int i = 0; i < DEPTH; i++) step(1, DW'(16'h100 + i), 0, 0, '0, '0);
      chk("R5 cap after frame 1", cap_valid, 1);

      // second frame while capture still busy: overflow
      for (int i = 0; i < DEPTH; i++) step(1, DW'(16'h200 + i), 0, 0, AW'(i), '0);
      chk("R3 overflow set", overflow, 1);
      for (int i = 0; i < 3; i++) step(1, DW'(16'hBAD0 + i), 0, 0, AW'(i), '0);
      chk("R3 dropped, addr held", wr_addr, 0);

      // release capture while a sample is offered during overflow
      step(1, DW'(16'hDEAD), 1, 0, '0, '0);
      chk("R9 overflow cleared", overflow, 0);
      chk("R9 sample dropped", wr_addr, 0);
      chk("R9 rotation", frame_count, 2);

      // final write coincides with both dones
      for (int i = 0; i < DEPTH - 1; i++) step(1, DW'(16'h300 + i), 0, 0, AW'(i), AW'(i));
      step(1, DW'(16'h3FF), 1, 1, '0, '0);
      chk("R8 no overflow", overflow, 0);
      chk("R8 immediate rotation", cap_start, 1);
      chk("R8 frame_count", frame_count, 3);

      // readback of the full processing bank
      for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 0, AW'(i), AW'(i));

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 10) < 7, DW'($urandom), ($urandom % 16) == 0, ($urandom % 16) == 0,
              AW'($urandom), AW'($urandom));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule